// File: doc/BRIEF.md
# SDA Hold-Delay and Input Deglitch Stage

This stage sits between the serial shift logic of a two-wire bus controller and the SDA pad. On the output side it holds the SDA drive request at its old level for a programmable number of peripheral clock cycles after each SCL falling edge. This gives the receiving devices the data hold time they need. On the input side it can reject short glitches on the SDA level that the pad returns, before the shift logic sees it.

A 3-bit line-control word sets the behaviour. Bits [1:0] form a hold code. Each unit of the code is a coarse step of `STEP_CYC` cycles, which is five by default. Bit 2 turns on the input deglitcher. The SCL generator supplies a one-cycle strobe on each SCL falling edge. The byte sequencer supplies the raw drive request, where 1 means pull SDA low. There is no data stream to throttle, so every pin is a plain level or strobe with no back-pressure.

A code of 0 together with bit 2 cleared makes the stage fully transparent. The upstream logic must keep `code × STEP_CYC` cycles shorter than the SCL low time, so the held level never reaches the next SCL rising edge.

Top module: `sda_line_ctrl`

## Requirements
- R1: When `scl_fall_stb` is sampled high and `line_cfg[1:0]` is a non-zero code N, `sda_drive_out` keeps the level it had in that cycle for exactly N×5 clock cycles, counted from that sampling edge. After that it follows `sda_drive_req` again.
- R2: With `line_cfg[1:0]` = 0, a strobe opens no hold window, and `sda_drive_out` equals `sda_drive_req` in the same cycle.
- R3: If `sda_drive_req` changes several times during a hold window, none of the intermediate values reaches `sda_drive_out`. Only the value present when the window closes appears.
- R4: Outside a hold window, for example around START and STOP with SCL high, `sda_drive_out` follows `sda_drive_req` with no cycle of delay.
- R5: With `line_cfg[2]` = 1, `sda_rx_out` takes a new level only after `sda_pad_in` has shown that level on 3 consecutive clock edges. It changes at the third of those edges, so pulses of 1 or 2 cycles have no effect.
- R6: With `line_cfg[2]` = 0, `sda_rx_out` equals `sda_pad_in` in the same cycle.
- R7: The hold length is taken from `line_cfg[1:0]` at the strobe only. Changing the code inside an open window neither shortens nor extends that window.
- R8: During and after reset no hold window is open, and the deglitched level starts at 1, the idle bus level.
- R9: A strobe that arrives while a window is still open restarts the window with the newly sampled code. The held level stays the one already on `sda_drive_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cfg | input | 3 | Line-control word: [1:0] hold code, [2] deglitch enable |
| scl_fall_stb | input | 1 | One-cycle strobe on each SCL falling edge |
| sda_drive_req | input | 1 | Raw SDA drive request from the sequencer (1 = pull low) |
| sda_pad_in | input | 1 | SDA level seen at the pad |
| sda_drive_out | output | 1 | Hold-delayed SDA drive to the pad |
| sda_rx_out | output | 1 | Deglitched or direct SDA level toward the shift logic |

## Verification
Suppose the hold counter has the wrong count. Then `sda_drive_out` flips from the held level to the request one or more cycles early or late, and a per-cycle comparison catches it at the first cycle of disagreement after a strobe. A wrong held value shows up on `sda_drive_out` in the very cycle after the strobe. A wrong run count in the deglitcher shows up as `sda_rx_out` moving on a 2-cycle pulse, or lagging a 3-cycle level, at the third edge. Reconfiguring the code mid-window and strobing twice inside one window expose counters that re-read the configuration or fail to reload.

// File: rtl/sda_lc_pkg.sv
package sda_lc_pkg;

  localparam int LC_CODE_W = 2;
  localparam int LC_CFG_W  = LC_CODE_W + 1;

  typedef struct packed {
    logic                 filt_en;
    logic [LC_CODE_W-1:0] hold_code;
  } lc_cfg_t;

  function automatic int max_hold_cycles(input int step_cyc);
    return ((1 << LC_CODE_W) - 1) * step_cyc;
  endfunction

  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/sda_lc_cfg_split.sv
module sda_lc_cfg_split
  import sda_lc_pkg::*;
(
  input  logic [LC_CFG_W-1:0]  cfg_word,
  output logic [LC_CODE_W-1:0] hold_code,
  output logic                 filt_en
);
  lc_cfg_t cfg_s;

  assign cfg_s     = lc_cfg_t'(cfg_word);
  assign hold_code = cfg_s.hold_code;
  assign filt_en   = cfg_s.filt_en;
endmodule

// File: rtl/sda_hold_delay.sv
module sda_hold_delay
  import sda_lc_pkg::*;
#(
  parameter int STEP_CYC = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LC_CODE_W-1:0] hold_code,
  input  logic                 fall_stb,
  input  logic                 drive_req,
  output logic                 drive_out
);
  localparam int MAX_HOLD = max_hold_cycles(STEP_CYC);
  localparam int CNT_W    = width_for(MAX_HOLD);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] load_val;
  logic             held_q;
  logic             arm;

  // Window length: code times the coarse step.
  assign load_val = CNT_W'(hold_code) * CNT_W'(STEP_CYC);
  assign arm      = fall_stb && (hold_code != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      held_q   <= 1'b0;
    end else if (arm) begin
      remain_q <= load_val;
      held_q   <= drive_out;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  // Latest request wins: the pad sees drive_req as soon as the window closes.
  assign drive_out = (remain_q != '0) ? held_q : drive_req;
endmodule

// File: rtl/sda_glitch_filter.sv
module sda_glitch_filter
  import sda_lc_pkg::*;
#(
  parameter int STABLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pad_in,
  output logic rx_out
);
  localparam int RUN_W = width_for(STABLE_N - 1);

  logic             level_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (!en) begin
      level_q <= pad_in;
      run_q   <= '0;
    end else if (pad_in != level_q) begin
      if (run_q == RUN_W'(STABLE_N - 1)) begin
        level_q <= pad_in;
        run_q   <= '0;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end else begin
      run_q <= '0;
    end
  end

  assign rx_out = en ? level_q : pad_in;
endmodule

// File: rtl/sda_line_ctrl.sv
module sda_line_ctrl
  import sda_lc_pkg::*;
#(
  parameter int STEP_CYC = 5,
  parameter int STABLE_N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LC_CFG_W-1:0] line_cfg,
  input  logic                scl_fall_stb,
  input  logic                sda_drive_req,
  input  logic                sda_pad_in,
  output logic                sda_drive_out,
  output logic                sda_rx_out
);
  logic [LC_CODE_W-1:0] hold_code;
  logic                 filt_en;

  sda_lc_cfg_split u_cfg (
    .cfg_word  (line_cfg),
    .hold_code (hold_code),
    .filt_en   (filt_en)
  );

  sda_hold_delay #(.STEP_CYC(STEP_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_code (hold_code),
    .fall_stb  (scl_fall_stb),
    .drive_req (sda_drive_req),
    .drive_out (sda_drive_out)
  );

  generate
    if (STABLE_N > 1) begin : g_filt
      sda_glitch_filter #(.STABLE_N(STABLE_N)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (filt_en),
        .pad_in (sda_pad_in),
        .rx_out (sda_rx_out)
      );
    end else begin : g_nofilt
      assign sda_rx_out = sda_pad_in;
    end
  endgenerate
endmodule

// File: rtl/sda_line_ctrl_chk.sv
module sda_line_ctrl_chk
  import sda_lc_pkg::*;
#(
  parameter int STEP_CYC = 5,
  parameter int STABLE_N = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LC_CFG_W-1:0] line_cfg,
  input logic                scl_fall_stb,
  input logic                sda_drive_req,
  input logic                sda_pad_in,
  input logic                sda_drive_out,
  input logic                sda_rx_out
);
  localparam int WIN_W  = width_for(max_hold_cycles(STEP_CYC));
  localparam int DIFF_W = width_for(STABLE_N);

  logic [WIN_W-1:0]  win_c;
  logic [DIFF_W-1:0] diff_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_c <= '0;
    end else if (scl_fall_stb && line_cfg[1:0] != 2'b00) begin
      win_c <= WIN_W'(line_cfg[1:0]) * WIN_W'(STEP_CYC);
    end else if (win_c != '0) begin
      win_c <= win_c - WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_c <= '0;
    end else if (line_cfg[2] && sda_pad_in != sda_rx_out) begin
      if (diff_c != DIFF_W'(STABLE_N)) diff_c <= diff_c + DIFF_W'(1);
    end else begin
      diff_c <= '0;
    end
  end

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_c != '0) |-> $stable(sda_drive_out));

  // R4
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_c == '0) |-> (sda_drive_out == sda_drive_req));

  // R5
  filt_min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cfg[2] && $past(line_cfg[2]) && sda_rx_out != $past(sda_rx_out))
      |-> (diff_c >= DIFF_W'(STABLE_N)));

  // R6
  filt_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_cfg[2] |-> (sda_rx_out == sda_pad_in));
endmodule

bind sda_line_ctrl sda_line_ctrl_chk #(.STEP_CYC(STEP_CYC), .STABLE_N(STABLE_N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_cfg      (line_cfg),
  .scl_fall_stb  (scl_fall_stb),
  .sda_drive_req (sda_drive_req),
  .sda_pad_in    (sda_pad_in),
  .sda_drive_out (sda_drive_out),
  .sda_rx_out    (sda_rx_out)
);

// File: tb/sda_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module sda_line_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] line_cfg = 3'b000;
  logic       scl_fall_stb = 1'b0;
  logic       sda_drive_req = 1'b0;
  logic       sda_pad_in = 1'b1;
  logic       sda_drive_out;
  logic       sda_rx_out;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R8";

  // Behavioural reference state
  int m_win = 0;
  bit m_held = 1'b0;
  bit m_filt = 1'b1;
  int m_run = 0;

  always #2.5 clk = ~clk;

  sda_line_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_cfg      (line_cfg),
    .scl_fall_stb  (scl_fall_stb),
    .sda_drive_req (sda_drive_req),
    .sda_pad_in    (sda_pad_in),
    .sda_drive_out (sda_drive_out),
    .sda_rx_out    (sda_rx_out)
  );

  function automatic bit exp_drive();
    return (m_win > 0) ? m_held : sda_drive_req;
  endfunction

  function automatic bit exp_rx();
    return line_cfg[2] ? m_filt : sda_pad_in;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_held = 1'b0; m_filt = 1'b1; m_run = 0;
    end else begin
      bit cur;
      cur = exp_drive();
      if (scl_fall_stb && line_cfg[1:0] != 2'd0) begin
        m_held = cur;
        m_win  = int'(line_cfg[1:0]) * 5;
      end else if (m_win > 0) begin
        m_win--;
      end
      if (!line_cfg[2]) begin
        m_filt = sda_pad_in; m_run = 0;
      end else if (sda_pad_in != m_filt) begin
        if (m_run == 2) begin m_filt = sda_pad_in; m_run = 0; end
        else m_run++;
      end else begin
        m_run = 0;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    vectors++;
    if (sda_drive_out !== exp_drive()) begin
      miscompares++;
      $display("FAIL %s sda_drive_out actual=%b expected=%b t=%0t", cur_req, sda_drive_out, exp_drive(), $time);
    end
    vectors++;
    if (sda_rx_out !== exp_rx()) begin
      miscompares++;
      $display("FAIL %s sda_rx_out actual=%b expected=%b t=%0t", cur_req, sda_rx_out, exp_rx(), $time);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); scl_fall_stb = 1'b1;
    @(negedge clk); scl_fall_stb = 1'b0;
  endtask

  task automatic pad_pulse(input bit lvl, input int len);
    @(negedge clk); sda_pad_in = lvl;
    cyc(len - 1);
    @(negedge clk); sda_pad_in = ~lvl;
    cyc(6);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: reset state, deglitch on with pad low -> rx must read 1
    line_cfg = 3'b100; sda_pad_in = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    sda_pad_in = 1'b1;
    cyc(3);

    // R2: code 0, strobes open no window
    cur_req = "R2"; line_cfg = 3'b000;
    for (int i = 0; i < 4; i++) begin
      strobe(); sda_drive_req = ~sda_drive_req; cyc(3);
    end

    // R1: each non-zero code holds code*5 cycles
    cur_req = "R1";
    for (int c = 1; c < 4; c++) begin
      line_cfg = 3'(c);
      strobe(); sda_drive_req = ~sda_drive_req; cyc(20);
    end

    // R3: several requests inside one window, latest wins
    cur_req = "R3"; line_cfg = 3'b011;
    strobe();
    for (int i = 0; i < 5; i++) begin sda_drive_req = ~sda_drive_req; cyc(2); end
    cyc(12);

    // R4: no window, changes pass straight through
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin @(negedge clk); sda_drive_req = ~sda_drive_req; end
    cyc(3);

    // R7: code change mid-window ignored
    cur_req = "R7"; line_cfg = 3'b001;
    strobe(); sda_drive_req = ~sda_drive_req; cyc(1);
    line_cfg = 3'b011; cyc(20);
    line_cfg = 3'b011;
    strobe(); sda_drive_req = ~sda_drive_req; cyc(2);
    line_cfg = 3'b001; cyc(20);

    // R9: second strobe restarts the window
    cur_req = "R9"; line_cfg = 3'b010;
    strobe(); sda_drive_req = ~sda_drive_req; cyc(4);
    strobe(); cyc(1); sda_drive_req = ~sda_drive_req; cyc(20);

    // R5: deglitch on, short pulses rejected, 3+ accepted
    cur_req = "R5"; line_cfg = 3'b100; sda_pad_in = 1'b1; cyc(4);
    pad_pulse(1'b0, 1);
    pad_pulse(1'b0, 2);
    pad_pulse(1'b0, 3);
    pad_pulse(1'b0, 5);
    @(negedge clk); sda_pad_in = 1'b0; cyc(8);
    pad_pulse(1'b1, 2);
    pad_pulse(1'b1, 4);

    // R6: deglitch off, pad passes through
    cur_req = "R6"; line_cfg = 3'b000;
    pad_pulse(1'b1, 1);
    pad_pulse(1'b0, 1);

    // Mixed random traffic
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 63) == 0) line_cfg = 3'($urandom_range(0, 7));
      scl_fall_stb = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 3) == 0) sda_drive_req = ~sda_drive_req;
      if ($urandom_range(0, 2) == 0) sda_pad_in = ~sda_pad_in;
    end
    scl_fall_stb = 1'b0;
    cyc(20);
    finish_run();
  end
endmodule